// File: doc/BRIEF.md
# Cache Array Debug Window

This block lets software reach straight into the storage of a two-way cache over a plain 32-bit bus. Three fixed address windows lead to the way 0 data array, the way 1 data array and the per-line tag array. Software uses them to clear or preload the cache, or to inspect it. The data windows hold plain 32-bit words. In the tag window each 36-bit line entry is split over two bus words. How it is split depends on a cache-size input, which selects either 16-bit or 17-bit way tags.

The windows only open while the cache is switched off. An access made while the cache is on is refused: a read returns zero, a write changes nothing, and an error strobe pulses for one cycle. Addresses outside all three windows are harmless. The arrays are simple synchronous storage inside the block. Read data comes back one cycle after the request, qualified by a valid strobe.

Top module: `cache_array_port`

## Requirements
- R1: A word written at 0x10000000 + 4*i (i = 0..511, address bits [1:0] ignored) while the cache is off reads back unchanged from the same address.
- R2: The way 1 window at 0x10800000 + 4*i (i = 0..511) is separate storage: a write there never changes the way 0 word at the same offset, and the reverse also holds.
- R3: In the tag window, the word at 0x11000000 + 8*n holds line n's way 1 tag bits [15:0] on bus bits [31:16] and its way 0 tag bits [15:0] on bus bits [15:0], for both reads and writes.
- R4: When `small_cache` is 0 (16-bit tags), the word at 0x11000000 + 8*n + 4 carries the 2-bit line status on bits [31:30]. Bits [29:0] read as zero. Writing it changes only the status, so stored tag bit 16 of either way is kept.
- R5: When `small_cache` is 1 (17-bit tags), that same word also carries way 1 tag bit 16 on bit 29 and way 0 tag bit 16 on bit 28, readable and writable. Bits [27:0] read as zero.
- R6: While `cache_on` is 1, a request that hits any window reads back zero, leaves all storage unchanged, and raises `bus_err` for exactly one cycle, in the cycle after the request.
- R7: A request outside all three windows reads back zero, writes nothing, and never raises `bus_err`, whatever the state of `cache_on`.
- R8: Every read request produces `bus_rvalid` high together with its data in the following cycle. A write request leaves `bus_rvalid` low.
- R9: While reset is held and after it releases, `bus_rvalid` and `bus_err` are 0 and `bus_rdata` is zero until the first request.
- R10: Tag lines sit 8 bytes apart: line 63 is at 0x110001F8. Writing one line never changes another line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cache_on | input | 1 | Cache enabled; while high the windows are closed |
| small_cache | input | 1 | 1 selects 17-bit tags, 0 selects 16-bit tags |
| bus_sel | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_err | output | 1 | One-cycle pulse: window request refused because the cache is on |

## Verification
The bench targets the split tag word. It writes the status word in 16-bit mode and then reads it in 17-bit mode. A design that let that write reach the bit-16 tags would show changed bits 29:28. A design that failed to mask them would show stray ones when reading in 16-bit mode. It also aims at refused accesses: a write made while the cache is on, followed by a read with the cache off, exposes a design that let the write through. An idle cycle after the refused request catches an error flag that stays high. Addresses just past each window end and aliasing between the two ways, which have equal offsets, cover the decode boundaries.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_WAY0 = 2'd1,
    RGN_WAY1 = 2'd2,
    RGN_TAG  = 2'd3
  } region_e;

  typedef struct packed {
    logic [1:0]  status;
    logic [16:0] tag_w1;
    logic [16:0] tag_w0;
  } tag_line_t;

endpackage

// File: rtl/cap_decode.sv
module cap_decode
  import cap_pkg::*;
#(
  parameter logic [31:0] BASE_WAY0  = 32'h1000_0000,
  parameter logic [31:0] BASE_WAY1  = 32'h1080_0000,
  parameter logic [31:0] BASE_TAG   = 32'h1100_0000,
  parameter int          DATA_WORDS = 512,
  parameter int          TAG_LINES  = 64
) (
  input  logic [31:0]                   addr,
  output region_e                       region,
  output logic [$clog2(DATA_WORDS)-1:0] data_idx,
  output logic [$clog2(TAG_LINES)-1:0]  line_idx,
  output logic                          upper_word
);

  localparam int DIDX_W  = $clog2(DATA_WORDS);
  localparam int LIDX_W  = $clog2(TAG_LINES);
  localparam int DSPAN_W = DIDX_W + 2;
  localparam int TSPAN_W = LIDX_W + 3;

  logic in_way0, in_way1, in_tag;
  logic unused_byte_bits;

  assign in_way0 = (addr[31:DSPAN_W] == BASE_WAY0[31:DSPAN_W]);
  assign in_way1 = (addr[31:DSPAN_W] == BASE_WAY1[31:DSPAN_W]);
  assign in_tag  = (addr[31:TSPAN_W] == BASE_TAG[31:TSPAN_W]);

  always_comb begin
    if (in_way0)      region = RGN_WAY0;
    else if (in_way1) region = RGN_WAY1;
    else if (in_tag)  region = RGN_TAG;
    else              region = RGN_NONE;
  end

  assign data_idx         = addr[DSPAN_W-1:2];
  assign line_idx         = addr[TSPAN_W-1:3];
  assign upper_word       = addr[2];
  assign unused_byte_bits = ^addr[1:0];

endmodule

// File: rtl/cap_data_ram.sv
module cap_data_ram #(
  parameter int WORDS = 512,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) begin
      q <= mem[idx];
    end
  end

  assign rdata = q;

endmodule

// File: rtl/cap_tag_store.sv
module cap_tag_store
  import cap_pkg::*;
#(
  parameter int LINES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic                     upper_word,
  input  logic                     small_cache,
  input  logic [BUS_W-1:0]         wdata,
  output logic [BUS_W-1:0]         rdata
);

  tag_line_t        mem [LINES];
  tag_line_t        cur_line;
  tag_line_t        merged;
  logic [BUS_W-1:0] packed_word;
  logic [BUS_W-1:0] q;

  assign cur_line = mem[idx];

  // Read-modify-write: only the fields carried by the addressed word change
  always_comb begin
    merged = cur_line;
    if (!upper_word) begin
      merged.tag_w1[15:0] = wdata[31:16];
      merged.tag_w0[15:0] = wdata[15:0];
    end else begin
      merged.status = wdata[31:30];
      if (small_cache) begin
        merged.tag_w1[16] = wdata[29];
        merged.tag_w0[16] = wdata[28];
      end
    end
  end

  always_comb begin
    if (!upper_word) begin
      packed_word = {cur_line.tag_w1[15:0], cur_line.tag_w0[15:0]};
    end else if (small_cache) begin
      packed_word = {cur_line.status, cur_line.tag_w1[16], cur_line.tag_w0[16], 28'd0};
    end else begin
      packed_word = {cur_line.status, 30'd0};
    end
  end

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[idx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en && !we) begin
      q <= packed_word;
    end
  end

  assign rdata = q;

  // R4
  wide_mode_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we && upper_word && !small_cache) |=> (rdata[29:0] == 30'd0));

  // R4
  wide_mode_keeps_bit16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we && upper_word && !small_cache) |=>
      ((mem[$past(idx)].tag_w0[16] == $past(cur_line.tag_w0[16])) &&
       (mem[$past(idx)].tag_w1[16] == $past(cur_line.tag_w1[16]))));

  // R5
  narrow_mode_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we && upper_word && small_cache) |=> (rdata[27:0] == 28'd0));

endmodule

// File: rtl/cache_array_port.sv
module cache_array_port
  import cap_pkg::*;
#(
  parameter logic [31:0] BASE_WAY0  = 32'h1000_0000,
  parameter logic [31:0] BASE_WAY1  = 32'h1080_0000,
  parameter logic [31:0] BASE_TAG   = 32'h1100_0000,
  parameter int          DATA_WORDS = 512,
  parameter int          TAG_LINES  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_on,
  input  logic        small_cache,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        bus_err
);

  localparam int DIDX_W = $clog2(DATA_WORDS);
  localparam int LIDX_W = $clog2(TAG_LINES);
  localparam int NWAYS  = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  // Address decode
  region_e           region;
  logic [DIDX_W-1:0] data_idx;
  logic [LIDX_W-1:0] line_idx;
  logic              upper_word;

  cap_decode #(
    .BASE_WAY0 (BASE_WAY0),
    .BASE_WAY1 (BASE_WAY1),
    .BASE_TAG  (BASE_TAG),
    .DATA_WORDS(DATA_WORDS),
    .TAG_LINES (TAG_LINES)
  ) u_decode (
    .addr      (bus_addr),
    .region    (region),
    .data_idx  (data_idx),
    .line_idx  (line_idx),
    .upper_word(upper_word)
  );

  // Access gating: windows open only with the cache off
  logic window_hit, open_req;
  logic [NWAYS-1:0] way_en;
  logic tag_en;

  assign window_hit = (region != RGN_NONE);
  assign open_req   = bus_sel && window_hit && !cache_on;
  assign way_en[0]  = open_req && (region == RGN_WAY0);
  assign way_en[1]  = open_req && (region == RGN_WAY1);
  assign tag_en     = open_req && (region == RGN_TAG);

  // Storage
  logic [BUS_W-1:0] way_q [NWAYS];
  logic [BUS_W-1:0] tag_q;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    cap_data_ram #(
      .WORDS(DATA_WORDS),
      .WIDTH(BUS_W)
    ) u_ram (
      .clk  (clk),
      .en   (way_en[w]),
      .we   (bus_we),
      .idx  (data_idx),
      .wdata(bus_wdata),
      .rdata(way_q[w])
    );
  end

  cap_tag_store #(
    .LINES(TAG_LINES)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (tag_en),
    .we         (bus_we),
    .idx        (line_idx),
    .upper_word (upper_word),
    .small_cache(small_cache),
    .wdata      (bus_wdata),
    .rdata      (tag_q)
  );

  // Response state: next-state logic
  logic    rvalid_d, rvalid_q;
  logic    err_d, err_q;
  region_e src_d, src_q;

  always_comb begin
    rvalid_d = bus_sel && !bus_we;
    err_d    = bus_sel && window_hit && cache_on;
    src_d    = (open_req && !bus_we) ? region : RGN_NONE;
  end

  // Response state: registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      src_q    <= RGN_NONE;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      src_q    <= src_d;
    end
  end

  // Read data steering
  always_comb begin
    case (src_q)
      RGN_WAY0: bus_rdata = way_q[0];
      RGN_WAY1: bus_rdata = way_q[1];
      RGN_TAG:  bus_rdata = tag_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;

  // R6
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_err |-> (bus_rdata == 32'd0));

  // R6
  closed_no_store_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    cache_on |-> ((way_en == '0) && !tag_en));

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({way_en, tag_en}));

  // R8
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !bus_we) |=> bus_rvalid);

  // R8
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && bus_we) |=> !bus_rvalid);

endmodule

// File: tb/cache_array_port_tb.sv
`timescale 1ns/1ps
module cache_array_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cache_on;
  logic        small_cache;
  logic        bus_sel;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        bus_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cache_array_port u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cache_on   (cache_on),
    .small_cache(small_cache),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err)
  );

  // Reference model
  logic [31:0] ref_w0 [512];
  logic [31:0] ref_w1 [512];
  logic [16:0] ref_t0 [64];
  logic [16:0] ref_t1 [64];
  logic [1:0]  ref_st [64];

  function automatic int where(input logic [31:0] a);
    if ((a & 32'hFFFF_F800) == 32'h1000_0000) return 1;
    if ((a & 32'hFFFF_F800) == 32'h1080_0000) return 2;
    if ((a & 32'hFFFF_FE00) == 32'h1100_0000) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic narrow);
    int i;
    int n;
    case (where(a))
      1: begin i = int'(a[10:2]); return ref_w0[i]; end
      2: begin i = int'(a[10:2]); return ref_w1[i]; end
      3: begin
        n = int'(a[8:3]);
        if (!a[2]) return {ref_t1[n][15:0], ref_t0[n][15:0]};
        if (narrow) return {ref_st[n], ref_t1[n][16], ref_t0[n][16], 28'd0};
        return {ref_st[n], 30'd0};
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic narrow);
    int i;
    int n;
    case (where(a))
      1: begin i = int'(a[10:2]); ref_w0[i] = d; end
      2: begin i = int'(a[10:2]); ref_w1[i] = d; end
      3: begin
        n = int'(a[8:3]);
        if (!a[2]) begin
          ref_t1[n][15:0] = d[31:16];
          ref_t0[n][15:0] = d[15:0];
        end else begin
          ref_st[n] = d[31:30];
          if (narrow) begin
            ref_t1[n][16] = d[29];
            ref_t0[n][16] = d[28];
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One request, one response cycle, then the bus goes idle
  task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d, input string rq);
    logic        hit;
    logic        e_err;
    logic [31:0] e_data;
    hit    = (where(a) != 0);
    e_err  = hit && cache_on;
    e_data = (hit && !cache_on) ? model_read(a, small_cache) : 32'd0;
    @(negedge clk);
    bus_sel   = 1'b1;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R8 rvalid", {31'd0, bus_rvalid}, {31'd0, !we});
    chk("R6 err", {31'd0, bus_err}, {31'd0, e_err});
    if (!we) chk(rq, bus_rdata, e_data);
    if (we && hit && !cache_on) model_write(a, d, small_cache);
  endtask

  task automatic idle_err_check(input string rq);
    @(negedge clk);
    chk(rq, {31'd0, bus_err}, 32'd0);
  endtask

  function automatic logic [31:0] rand_addr(output string rq);
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0, 1, 2: begin rq = "R1"; return 32'h1000_0000 | ($urandom & 32'h7FF); end
      3, 4, 5: begin rq = "R2"; return 32'h1080_0000 | ($urandom & 32'h7FF); end
      6, 7, 8: begin rq = "R3"; return 32'h1100_0000 | ($urandom & 32'h1FF); end
      default: begin
        rq = "R7";
        case ($urandom_range(0, 3))
          0: return 32'h1000_0800 | ($urandom & 32'hFC);
          1: return 32'h1080_0800 | ($urandom & 32'hFC);
          2: return 32'h1100_0200 | ($urandom & 32'hFC);
          default: return $urandom;
        endcase
      end
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n       = 1'b0;
    cache_on    = 1'b0;
    small_cache = 1'b1;
    bus_sel     = 1'b0;
    bus_we      = 1'b0;
    bus_addr    = '0;
    bus_wdata   = '0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk("R9 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
    chk("R9 err in reset", {31'd0, bus_err}, 32'd0);
    chk("R9 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    chk("R9 rdata after reset", bus_rdata, 32'd0);

    // Fill all storage with known data (17-bit mode)
    for (int i = 0; i < 512; i++) begin
      do_op(1'b1, 32'h1000_0000 + 32'(4 * i), $urandom, "R1");
      do_op(1'b1, 32'h1080_0000 + 32'(4 * i), $urandom, "R2");
    end
    for (int n = 0; n < 64; n++) begin
      do_op(1'b1, 32'h1100_0000 + 32'(8 * n), $urandom, "R3");
      do_op(1'b1, 32'h1100_0004 + 32'(8 * n), $urandom, "R5");
    end

    // R1 / R2: same offset, separate ways
    do_op(1'b1, 32'h1000_0014, 32'hA5A5_1234, "R1");
    do_op(1'b1, 32'h1080_0014, 32'h5A5A_CDEF, "R2");
    do_op(1'b0, 32'h1000_0014, 32'h0, "R1 way0 word");
    do_op(1'b0, 32'h1080_0014, 32'h0, "R2 way1 word");
    do_op(1'b0, 32'h1000_07FF, 32'h0, "R1 last word, byte bits ignored");

    // R3 / R10: first and last tag line
    do_op(1'b1, 32'h1100_0000, 32'h1111_2222, "R3");
    do_op(1'b1, 32'h1100_01F8, 32'hBEEF_CAFE, "R10");
    do_op(1'b0, 32'h1100_0000, 32'h0, "R3 line0 low word");
    do_op(1'b0, 32'h1100_01F8, 32'h0, "R10 line63 low word");
    do_op(1'b0, 32'h1100_0008, 32'h0, "R10 line1 untouched");

    // R5: 17-bit mode upper word
    small_cache = 1'b1;
    do_op(1'b1, 32'h1100_001C, 32'hFFFF_FFFF, "R5");
    do_op(1'b0, 32'h1100_001C, 32'h0, "R5 narrow upper word");

    // R4: 16-bit mode keeps bit 16 of both tags
    small_cache = 1'b0;
    do_op(1'b1, 32'h1100_001C, 32'h4000_0000, "R4");
    do_op(1'b0, 32'h1100_001C, 32'h0, "R4 wide upper word");
    small_cache = 1'b1;
    do_op(1'b0, 32'h1100_001C, 32'h0, "R4 bit16 kept");

    // R6: refused while cache is on
    cache_on = 1'b1;
    do_op(1'b1, 32'h1000_0014, 32'hDEAD_0001, "R6");
    idle_err_check("R6 err one cycle");
    do_op(1'b1, 32'h1100_0000, 32'hDEAD_0002, "R6");
    do_op(1'b0, 32'h1080_0014, 32'h0, "R6 refused read zero");
    // R7: outside windows, cache on
    do_op(1'b0, 32'h1000_0800, 32'h0, "R7 no err, zero");
    cache_on = 1'b0;
    do_op(1'b0, 32'h1000_0014, 32'h0, "R6 write dropped way0");
    do_op(1'b0, 32'h1100_0000, 32'h0, "R6 write dropped tag");

    // R7: writes just past each window land nowhere
    do_op(1'b1, 32'h1000_0800, 32'h0BAD_0BAD, "R7");
    do_op(1'b1, 32'h1100_0200, 32'h0BAD_0BAD, "R7");
    do_op(1'b0, 32'h1000_0000, 32'h0, "R7 way0 word0 unchanged");
    do_op(1'b0, 32'h1100_0000, 32'h0, "R7 tag line0 unchanged");
    do_op(1'b0, 32'h1080_0800, 32'h0, "R7 outside read zero");

    // Random mix
    for (int t = 0; t < 3000; t++) begin
      string       rq;
      logic [31:0] a;
      a = rand_addr(rq);
      if ($urandom_range(0, 15) == 0) cache_on = 1'b1;
      else cache_on = 1'b0;
      small_cache = $urandom_range(0, 1) == 1;
      if (cache_on && where(a) != 0) rq = "R6";
      else if (rq == "R3" && a[2]) rq = small_cache ? "R5" : "R4";
      do_op($urandom_range(0, 1) == 1, a, $urandom, rq);
    end
    cache_on = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule